// File: doc/BRIEF.md
# Block Cipher Register Front-End

This block sits between a 32-bit register bus and a 64-bit block cipher core that is reached through a start/done handshake. Software, or a DMA engine, loads a key of up to six words, an optional chaining value and a mode. It then pushes each 64-bit block as two data words and reads each result back from the same two addresses. The front-end builds the block and starts the core. It applies cipher-block chaining around the core and keeps the chaining value current so that a stream can be resumed. It also counts a programmed byte length down.

Pacing is one block at a time. A data-in event means the front-end will take a new block. A data-out event means a result is waiting. The two events reach the host either as an interrupt, gated per event by an enable register, or as DMA requests. A new data-in event is raised only after the host has read the previous result.

Top module: `cfp_top`

## Requirements
- R1: After reset, every register reads zero except control, which reads 0x2 (input-ready), and the revision register. The interrupt, DMA request and core start outputs are low.
- R2: Key word i is written at byte address 0x14 - 4*(i XOR 1), giving word 0..5 at 0x10, 0x14, 0x08, 0x0C, 0x00, 0x04. The core key bus is {word0, word1, ..., word5}, with word0 in the top bits. Key words read back at their addresses.
- R3: Control at 0x20: bit 4 selects chaining, bit 3 selects triple-key, bit 2 = 1 selects encrypt. Read-only bit 1 is 1 while no block is held, and read-only bit 0 is 1 while a result waits to be read.
- R4: Writing 0x28 stores the high data word. Writing 0x2C while idle raises core_start for exactly one cycle and presents the block {high, low}. Data writes made while a block is held are ignored.
- R5: In ECB mode the core result is returned unchanged, high word at 0x28 and low word at 0x2C.
- R6: In chained encrypt the core receives input XOR IV, and the IV (high word 0x18, low word 0x1C) is then loaded with the core output.
- R7: In chained decrypt the result is core output XOR IV, and the IV is then loaded with the ciphertext that was input. An encrypt followed by a decrypt from the same IV restores the plaintext.
- R8: The length register at 0x24 loses 8 on each completed block and stops at 0 when fewer than 8 remain.
- R9: Status at 0x3C has bit 2 (data-out), which sets when the core finishes, and bit 1 (data-in), which sets when the low result word is read, or when a nonzero length is written while idle. A write ANDs the status with the written value, so writing 0 clears a bit. The irq output is high while any status bit has its bit set in the enable register at 0x40.
- R10: The mask register at 0x34 holds bit 3 (start), bit 5 (input DMA) and bit 6 (output DMA). The input request is high when start and bit 5 are set, the block is idle and the length is nonzero. The output request is high when start and bit 6 are set and a result waits.
- R11: Writes to key, IV or control while the core is working on a block are ignored.
- R12: The revision register at 0x30 returns the major number in bits 10:8 and the minor number in bits 5:0, all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read of 0x2C releases the result) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt, OR of enabled status bits |
| dma_in_req | output | 1 | Request for the next input block |
| dma_out_req | output | 1 | Request to collect a result block |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_blk_in | output | 64 | Block presented to the core |
| core_key | output | 192 | Key words, word 0 in the top bits |
| core_triple | output | 1 | Triple-key mode select |
| core_encrypt | output | 1 | Direction select, 1 = encrypt |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_blk_out | input | 64 | Core result, valid with core_done |

## Verification
The hardest situation to reach is a register write that lands while the core is still working on a block, because the busy window is only a few cycles long and is visible at the ports only through the missing ready flags. The bench drives key, IV and control writes on the cycles right after the low data word. It then shows that the result was computed with the old key and that every register reads back its old value. Chaining is checked by sweeping all eight mode combinations over several blocks and following the IV arithmetically. An encrypt-then-decrypt round trip confirms that the two chaining directions mirror each other.

// File: rtl/cfp_pkg.sv
// Shared definitions for the cipher register front-end.
// Assumes a byte-addressed bus with 32-bit registers on word boundaries.
package cfp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_OUT  = 2'd2
    } blk_state_e;

    localparam int A_IV_HI  = 'h18;
    localparam int A_IV_LO  = 'h1C;
    localparam int A_CTRL   = 'h20;
    localparam int A_LEN    = 'h24;
    localparam int A_DATA0  = 'h28;
    localparam int A_DATA1  = 'h2C;
    localparam int A_REV    = 'h30;
    localparam int A_MASK   = 'h34;
    localparam int A_STAT   = 'h3C;
    localparam int A_IRQEN  = 'h40;

    // Key words sit below 0x14 in pair-swapped descending order.
    function automatic int key_addr(input int idx);
        return 'h14 - 4 * (idx ^ 1);
    endfunction

endpackage

// File: rtl/cfp_chain.sv
// Chaining datapath: XOR with the IV before or after the core, and the next IV.
// Assumes the caller only loads the IV when chaining is enabled.
module cfp_chain #(
    parameter int BLK_W = 64
) (
    input  logic             cbc,
    input  logic             enc,
    input  logic [BLK_W-1:0] iv,
    input  logic [BLK_W-1:0] new_blk,
    input  logic [BLK_W-1:0] held_blk,
    input  logic [BLK_W-1:0] core_out,
    output logic [BLK_W-1:0] pre_blk,
    output logic [BLK_W-1:0] post_blk,
    output logic [BLK_W-1:0] iv_next
);

    // Whitening before the core (encrypt) and after it (decrypt).
    always_comb begin
        pre_blk  = (cbc && enc)  ? (new_blk ^ iv) : new_blk;
        post_blk = (cbc && !enc) ? (core_out ^ iv) : core_out;
        iv_next  = enc ? core_out : held_blk;
    end

endmodule

// File: rtl/cfp_fsm.sv
// Block sequencer: gathers two data words, starts the core, holds the
// result until the low word is read. Assumes core_done arrives once per start.
module cfp_fsm
    import cfp_pkg::*;
#(
    parameter int BLK_W  = 64,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BLK_W/2-1:0]  bus_wdata,
    input  logic [BLK_W-1:0]    pre_blk,
    input  logic [BLK_W-1:0]    post_blk,
    input  logic                core_done,
    output blk_state_e          state,
    output logic [BLK_W/2-1:0]  w0_q,
    output logic [BLK_W-1:0]    held_blk,
    output logic [BLK_W-1:0]    out_blk,
    output logic [BLK_W-1:0]    core_blk_in,
    output logic                core_start,
    output logic                blk_done,
    output logic                out_taken
);

    localparam int HALF = BLK_W / 2;

    logic wr_lo, wr_hi, rd_hi;

    // Decode the data-port strobes.
    always_comb begin
        wr_lo     = bus_wr && (bus_addr == ADDR_W'(A_DATA0));
        wr_hi     = bus_wr && (bus_addr == ADDR_W'(A_DATA1));
        rd_hi     = bus_rd && (bus_addr == ADDR_W'(A_DATA1));
        blk_done  = (state == ST_BUSY) && core_done;
        out_taken = (state == ST_OUT) && rd_hi;
    end

    // Sequence one block: idle -> core busy -> result waiting -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            w0_q        <= '0;
            held_blk    <= '0;
            out_blk     <= '0;
            core_blk_in <= '0;
            core_start  <= 1'b0;
        end else begin
            core_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (wr_lo) w0_q <= bus_wdata;
                    if (wr_hi) begin
                        held_blk    <= {w0_q, bus_wdata[HALF-1:0]};
                        core_blk_in <= pre_blk;
                        core_start  <= 1'b1;
                        state       <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (core_done) begin
                        out_blk <= post_blk;
                        state   <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (rd_hi) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfp_regs.sv
// Register file: key, IV, control, length, DMA mask, interrupt status and
// enable, and the read mux. Assumes one bus access per cycle.
module cfp_regs
    import cfp_pkg::*;
#(
    parameter int KEY_WORDS = 6,
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 64,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  blk_state_e                  state,
    input  logic [BLK_W-1:0]            out_blk,
    input  logic [BLK_W-1:0]            iv_next,
    input  logic                        blk_done,
    input  logic                        out_taken,
    output logic [KEY_WORDS*32-1:0]     key_flat,
    output logic [BLK_W-1:0]            iv_q,
    output logic                        cbc_q,
    output logic                        triple_q,
    output logic                        enc_q,
    output logic [31:0]                 len_q,
    output logic                        irq,
    output logic                        dma_in_req,
    output logic                        dma_out_req,
    output logic [31:0]                 bus_rdata
);

    localparam int WORD_W = 32;
    localparam int KEY_W  = KEY_WORDS * WORD_W;

    logic       busy, idle, outr;
    logic       wr_iv_hi, wr_iv_lo, wr_ctrl, wr_len, wr_mask, wr_stat, wr_en;
    logic       dma_go_q, dma_in_en_q, dma_out_en_q;
    logic [1:0] stat_q, en_q, stat_nxt;
    logic       in_set;

    // Decode state and write strobes.
    always_comb begin
        busy     = (state == ST_BUSY);
        idle     = (state == ST_IDLE);
        outr     = (state == ST_OUT);
        wr_iv_hi = bus_wr && (bus_addr == ADDR_W'(A_IV_HI));
        wr_iv_lo = bus_wr && (bus_addr == ADDR_W'(A_IV_LO));
        wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
        wr_len   = bus_wr && (bus_addr == ADDR_W'(A_LEN));
        wr_mask  = bus_wr && (bus_addr == ADDR_W'(A_MASK));
        wr_stat  = bus_wr && (bus_addr == ADDR_W'(A_STAT));
        wr_en    = bus_wr && (bus_addr == ADDR_W'(A_IRQEN));
        in_set   = out_taken || (wr_len && (bus_wdata != '0) && idle);
    end

    // One register per key word at its swapped address.
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
        localparam logic [ADDR_W-1:0] KADDR = ADDR_W'(key_addr(g));
        logic [WORD_W-1:0] kq;
        // Key word storage, frozen while the core is busy.
        always_ff @(posedge clk) begin
            if (!rst_n) kq <= '0;
            else if (bus_wr && !busy && (bus_addr == KADDR)) kq <= bus_wdata;
        end
        assign key_flat[KEY_W-1-WORD_W*g -: WORD_W] = kq;
    end

    // Chaining value: host writes when not busy, wrapper update on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q <= '0;
        end else if (blk_done && cbc_q) begin
            iv_q <= iv_next;
        end else if (!busy) begin
            if (wr_iv_hi) iv_q[BLK_W-1 -: WORD_W] <= bus_wdata;
            if (wr_iv_lo) iv_q[WORD_W-1:0]        <= bus_wdata;
        end
    end

    // Mode bits, frozen while the core is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbc_q    <= 1'b0;
            triple_q <= 1'b0;
            enc_q    <= 1'b0;
        end else if (wr_ctrl && !busy) begin
            cbc_q    <= bus_wdata[4];
            triple_q <= bus_wdata[3];
            enc_q    <= bus_wdata[2];
        end
    end

    // Byte length: host write wins, otherwise count down per block, floor zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        len_q <= '0;
        else if (wr_len)   len_q <= bus_wdata;
        else if (blk_done) len_q <= (len_q >= 32'd8) ? (len_q - 32'd8) : '0;
    end

    // DMA mask and interrupt enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_go_q     <= 1'b0;
            dma_in_en_q  <= 1'b0;
            dma_out_en_q <= 1'b0;
            en_q         <= '0;
        end else begin
            if (wr_mask) begin
                dma_go_q     <= bus_wdata[3];
                dma_in_en_q  <= bus_wdata[5];
                dma_out_en_q <= bus_wdata[6];
            end
            if (wr_en) en_q <= bus_wdata[2:1];
        end
    end

    // Status next value: write ANDs, events set with priority.
    always_comb begin
        stat_nxt = stat_q;
        if (wr_stat)  stat_nxt = stat_q & bus_wdata[2:1];
        if (blk_done) stat_nxt[1] = 1'b1;
        if (in_set)   stat_nxt[0] = 1'b1;
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    // Request outputs.
    always_comb begin
        irq         = |(stat_q & en_q);
        dma_in_req  = dma_go_q && dma_in_en_q && idle && (len_q != '0);
        dma_out_req = dma_go_q && dma_out_en_q && outr;
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < KEY_WORDS; i++) begin
            if (bus_addr == ADDR_W'(key_addr(i)))
                bus_rdata = key_flat[KEY_W-1-WORD_W*i -: WORD_W];
        end
        if (bus_addr == ADDR_W'(A_IV_HI))      bus_rdata = iv_q[BLK_W-1 -: WORD_W];
        else if (bus_addr == ADDR_W'(A_IV_LO)) bus_rdata = iv_q[WORD_W-1:0];
        else if (bus_addr == ADDR_W'(A_CTRL))
            bus_rdata = {27'd0, cbc_q, triple_q, enc_q, idle, outr};
        else if (bus_addr == ADDR_W'(A_LEN))   bus_rdata = len_q;
        else if (bus_addr == ADDR_W'(A_DATA0)) bus_rdata = out_blk[BLK_W-1 -: WORD_W];
        else if (bus_addr == ADDR_W'(A_DATA1)) bus_rdata = out_blk[WORD_W-1:0];
        else if (bus_addr == ADDR_W'(A_REV))
            bus_rdata = {21'd0, 3'(REV_MAJOR), 2'd0, 6'(REV_MINOR)};
        else if (bus_addr == ADDR_W'(A_MASK))
            bus_rdata = {25'd0, dma_out_en_q, dma_in_en_q, 1'b0, dma_go_q, 3'd0};
        else if (bus_addr == ADDR_W'(A_STAT))  bus_rdata = {29'd0, stat_q, 1'b0};
        else if (bus_addr == ADDR_W'(A_IRQEN)) bus_rdata = {29'd0, en_q, 1'b0};
    end

endmodule

// File: rtl/cfp_top.sv
// Cipher register front-end top: ties the register file, block sequencer
// and chaining datapath together. Assumes an external core with a start/done
// handshake that holds core_blk_out valid while core_done is high.
module cfp_top
    import cfp_pkg::*;
#(
    parameter int KEY_WORDS = 6,
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 64,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1,
    localparam int KEY_W    = KEY_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              dma_in_req,
    output logic              dma_out_req,
    output logic              core_start,
    output logic [BLK_W-1:0]  core_blk_in,
    output logic [KEY_W-1:0]  core_key,
    output logic              core_triple,
    output logic              core_encrypt,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_blk_out
);

    blk_state_e         state;
    logic [BLK_W/2-1:0] w0_q;
    logic [BLK_W-1:0]   held_blk, out_blk, pre_blk, post_blk, iv_next, iv_q;
    logic               blk_done, out_taken, cbc_q;
    logic [31:0]        len_q;
    logic               st_busy, st_out;

    // State flags used by the bound checker.
    always_comb begin
        st_busy = (state == ST_BUSY);
        st_out  = (state == ST_OUT);
    end

    cfp_chain #(.BLK_W(BLK_W)) u_chain (
        .cbc      (cbc_q),
        .enc      (core_encrypt),
        .iv       (iv_q),
        .new_blk  ({w0_q, bus_wdata}),
        .held_blk (held_blk),
        .core_out (core_blk_out),
        .pre_blk  (pre_blk),
        .post_blk (post_blk),
        .iv_next  (iv_next)
    );

    cfp_fsm #(.BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .pre_blk     (pre_blk),
        .post_blk    (post_blk),
        .core_done   (core_done),
        .state       (state),
        .w0_q        (w0_q),
        .held_blk    (held_blk),
        .out_blk     (out_blk),
        .core_blk_in (core_blk_in),
        .core_start  (core_start),
        .blk_done    (blk_done),
        .out_taken   (out_taken)
    );

    cfp_regs #(
        .KEY_WORDS (KEY_WORDS),
        .ADDR_W    (ADDR_W),
        .BLK_W     (BLK_W),
        .REV_MAJOR (REV_MAJOR),
        .REV_MINOR (REV_MINOR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .state       (state),
        .out_blk     (out_blk),
        .iv_next     (iv_next),
        .blk_done    (blk_done),
        .out_taken   (out_taken),
        .key_flat    (core_key),
        .iv_q        (iv_q),
        .cbc_q       (cbc_q),
        .triple_q    (core_triple),
        .enc_q       (core_encrypt),
        .len_q       (len_q),
        .irq         (irq),
        .dma_in_req  (dma_in_req),
        .dma_out_req (dma_out_req),
        .bus_rdata   (bus_rdata)
    );

endmodule

// File: rtl/cfp_checker.sv
// Temporal checks on the front-end, attached to every cfp_top by bind.
module cfp_checker #(
    parameter int ADDR_W = 8,
    parameter int KEY_W  = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              core_start,
    input logic              core_done,
    input logic [KEY_W-1:0]  core_key,
    input logic              irq,
    input logic              dma_out_req,
    input logic [31:0]       len_q,
    input logic              st_busy,
    input logic              st_out
);

    logic len_wr;
    assign len_wr = bus_wr && (bus_addr == ADDR_W'(cfp_pkg::A_LEN));

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R4

    AST_OUT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_out) |-> $past(core_done)); // R3

    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(core_done && st_busy) && !$past(len_wr) && ($past(len_q) >= 32'd8))
        |-> (len_q == $past(len_q) - 32'd8)); // R8

    AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(core_done && st_busy) && !$past(len_wr) && ($past(len_q) < 32'd8))
        |-> (len_q == 32'd0)); // R8

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr)); // R9

    AST_DMA_OUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_out_req |-> st_out); // R10

    AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_busy && $past(st_busy)) |-> $stable(core_key)); // R11

endmodule

bind cfp_top cfp_checker #(.ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .core_start  (core_start),
    .core_done   (core_done),
    .core_key    (core_key),
    .irq         (irq),
    .dma_out_req (dma_out_req),
    .len_q       (len_q),
    .st_busy     (st_busy),
    .st_out      (st_out)
);

// File: tb/cfp_top_test.sv
module cfp_top_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq, dma_in_req, dma_out_req, core_start, core_triple, core_encrypt;
    logic [63:0]  core_blk_in;
    logic [191:0] core_key;
    logic         core_done;
    logic [63:0]  core_blk_out;

    int nchk = 0, nerr = 0, nstarts = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cfp_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .core_start(core_start), .core_blk_in(core_blk_in), .core_key(core_key),
        .core_triple(core_triple), .core_encrypt(core_encrypt),
        .core_done(core_done), .core_blk_out(core_blk_out)
    );

    // Invertible stand-in cipher.
    function automatic logic [63:0] stubf(input logic [63:0] x, input logic [63:0] k, input logic e);
        logic [63:0] t;
        if (e) begin t = x ^ k; return {t[56:0], t[63:57]}; end
        else   return {x[6:0], x[63:7]} ^ k;
    endfunction

    // Core stub: five-cycle latency, key folded per mode.
    logic [3:0]  scnt;
    logic [63:0] sblk, kf;
    logic        senc;
    assign kf = core_triple ? (core_key[191:128] ^ core_key[127:64] ^ core_key[63:0])
                            : core_key[191:128];
    always @(posedge clk) begin
        if (!rst_n) begin
            scnt <= '0; core_done <= 1'b0; core_blk_out <= '0; sblk <= '0; senc <= 1'b0;
        end else begin
            core_done <= 1'b0;
            if (core_start) begin
                scnt <= 4'd5; sblk <= core_blk_in; senc <= core_encrypt;
            end else if (scnt != 0) begin
                scnt <= scnt - 4'd1;
                if (scnt == 4'd1) begin
                    core_done <= 1'b1; core_blk_out <= stubf(sblk, kf, senc);
                end
            end
        end
    end

    always @(posedge clk) if (rst_n && core_start) nstarts++;

    logic [31:0] kw [6];

    function automatic logic [63:0] kfold(input logic tri_m);
        return tri_m ? ({kw[0], kw[1]} ^ {kw[2], kw[3]} ^ {kw[4], kw[5]}) : {kw[0], kw[1]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [63:0] b);
        wr(8'h28, b[63:32]);
        wr(8'h2C, b[31:0]);
        repeat (12) @(negedge clk);
    endtask

    task automatic pull(output logic [63:0] r);
        logic [31:0] hi, lo;
        rd(8'h28, hi);
        rd(8'h2C, lo);
        r = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] r, p, exp, miv, c0, c1, ivs;
        logic [7:0]  ka [6];
        int starts0;
        ka[0] = 8'h10; ka[1] = 8'h14; ka[2] = 8'h08; ka[3] = 8'h0C; ka[4] = 8'h00; ka[5] = 8'h04;
        for (int i = 0; i < 6; i++) kw[i] = 32'h0F1E2D3C * (i + 1) ^ 32'h5A5A0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h20, d); chk("R1 ctrl", d, 32'h2);
        rd(8'h3C, d); chk("R1 status", d, 0);
        rd(8'h24, d); chk("R1 length", d, 0);
        rd(8'h10, d); chk("R1 key", d, 0);
        rd(8'h18, d); chk("R1 iv", d, 0);
        chk("R1 outputs", {irq, dma_in_req, dma_out_req, core_start}, 0);

        // R12 revision
        rd(8'h30, d); chk("R12 revision", d, 32'h0000_0201);

        // R2 key map
        for (int i = 0; i < 6; i++) wr(ka[i], kw[i]);
        chk("R2 key bus hi", core_key[191:96], {kw[0], kw[1], kw[2]});
        chk("R2 key bus lo", core_key[95:0],  {kw[3], kw[4], kw[5]});
        rd(8'h00, d); chk("R2 readback 0x00", d, kw[4]);
        rd(8'h14, d); chk("R2 readback 0x14", d, kw[1]);

        // R3 R5 R6 R7 sweep of all modes
        for (int m = 0; m < 8; m++) begin
            logic cbc, tm, en;
            cbc = m[2]; tm = m[1]; en = m[0];
            wr(8'h20, 32'(m) << 2);
            rd(8'h20, d); chk("R3 ctrl mode", d, (32'(m) << 2) | 32'h2);
            miv = 64'h0123_4567_89AB_CDEF ^ 64'(m * 32'h1111);
            wr(8'h18, miv[63:32]); wr(8'h1C, miv[31:0]);
            ivs = miv;
            for (int b = 0; b < 3; b++) begin
                p = {32'h1111_1111 * (b + 1), 32'hCAFE_0000 + 32'(m * 16 + b)};
                push(p);
                if (cbc && en) chk("R6 core input", core_blk_in, p ^ miv);
                else           chk("R4 core input", core_blk_in, p);
                pull(r);
                if (!cbc)     exp = stubf(p, kfold(tm), en);
                else if (en) begin exp = stubf(p ^ miv, kfold(tm), 1'b1); miv = exp; end
                else         begin exp = stubf(p, kfold(tm), 1'b0) ^ miv; miv = p; end
                chk(cbc ? (en ? "R6 result" : "R7 result") : "R5 result", r, exp);
            end
            rd(8'h18, d); r[63:32] = d;
            rd(8'h1C, d); r[31:0] = d;
            chk(cbc ? "R6 R7 iv after run" : "R5 iv untouched", r, cbc ? miv : ivs);
        end

        // R7 round trip
        wr(8'h20, 32'h14);
        wr(8'h18, 32'hFEED_0001); wr(8'h1C, 32'hBEEF_0002);
        push(64'h0102_0304_0506_0708); pull(c0);
        push(64'h1112_1314_1516_1718); pull(c1);
        wr(8'h20, 32'h10);
        wr(8'h18, 32'hFEED_0001); wr(8'h1C, 32'hBEEF_0002);
        push(c0); pull(r); chk("R7 round trip 0", r, 64'h0102_0304_0506_0708);
        push(c1); pull(r); chk("R7 round trip 1", r, 64'h1112_1314_1516_1718);

        // R8 R9 length, status, interrupt
        wr(8'h20, 32'h4);
        wr(8'h3C, 0);
        wr(8'h24, 20);
        rd(8'h3C, d); chk("R9 data-in on length write", d, 32'h2);
        wr(8'h3C, 32'h6);
        rd(8'h3C, d); chk("R9 write one keeps", d, 32'h2);
        wr(8'h3C, 0);
        rd(8'h3C, d); chk("R9 write zero clears", d, 0);
        wr(8'h40, 32'h4);
        push(64'hAAAA_0000_5555_0001);
        chk("R9 irq on data-out", irq, 1);
        rd(8'h3C, d); chk("R9 no data-in before read", d, 32'h4);
        rd(8'h20, d); chk("R3 output ready", d, 32'h5);
        rd(8'h24, d); chk("R8 length 20 to 12", d, 12);
        wr(8'h3C, 0);
        chk("R9 irq cleared", irq, 0);
        pull(r);
        rd(8'h3C, d); chk("R9 data-in after read", d, 32'h2);
        rd(8'h20, d); chk("R3 input ready", d, 32'h6);
        push(64'h2); pull(r);
        rd(8'h24, d); chk("R8 length 12 to 4", d, 4);
        push(64'h3); pull(r);
        rd(8'h24, d); chk("R8 length floor", d, 0);
        wr(8'h40, 0);

        // R10 DMA requests
        wr(8'h24, 16);
        wr(8'h34, 32'h60);
        chk("R10 no start bit", {dma_in_req, dma_out_req}, 0);
        wr(8'h34, 32'h68);
        chk("R10 input request", {dma_in_req, dma_out_req}, 2'b10);
        push(64'h4);
        chk("R10 output request", {dma_in_req, dma_out_req}, 2'b01);
        pull(r);
        chk("R10 input request again", {dma_in_req, dma_out_req}, 2'b10);
        wr(8'h34, 0);

        // R11 writes while busy, R4 data write while result held
        wr(8'h20, 32'h4);
        wr(8'h18, 32'h1234_5678);
        p = 64'h7777_8888_9999_AAAA;
        wr(8'h28, p[63:32]);
        wr(8'h2C, p[31:0]);
        wr(8'h10, 32'hDEAD_BEEF);
        wr(8'h18, 32'hCAFE_CAFE);
        wr(8'h20, 32'h1C);
        repeat (10) @(negedge clk);
        starts0 = nstarts;
        wr(8'h2C, 32'h0BAD_0BAD);
        repeat (10) @(negedge clk);
        chk("R4 no start while held", 64'(nstarts), 64'(starts0));
        rd(8'h20, d); chk("R4 R11 ctrl unchanged", d, 32'h5);
        pull(r); chk("R11 result with old key", r, stubf(p, kfold(1'b0), 1'b1));
        rd(8'h10, d); chk("R11 key unchanged", d, kw[0]);
        rd(8'h18, d); chk("R11 iv unchanged", d, 32'h1234_5678);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule